// File: doc/BRIEF.md
# Turn Marker Selector and Regenerator

This block produces a clean once-per-turn marker in the bunch-clock domain. In automatic mode it locks onto one of several incoming turn markers, chosen by a select field. Each rising edge of the chosen input is delayed by a whole number of bunch clocks and then restarts an internal period counter. In manual mode the inputs are ignored and the marker free-runs at the programmed period. The output pulse is always regenerated locally with a programmable width, so a noisy or stretched input never reaches the output.

If the chosen input stops while in automatic mode, the generator keeps free-running at the programmed period. A sticky flag reports that the source has gone missing. A counter of generated markers can be read back. A general reset command returns the counters, the delay pipeline and the pulse generator to their initial state and leaves the configuration untouched. A small register port with combinational reads holds the configuration.

Top module: `orbit_marker_gen`

## Requirements
- R1: After rst_n is released, orbit_out and orbit_lost are low, the marker count reads 0, the control register reads 0 (manual mode, source 0) and the period register reads 3564.
- R2: In manual mode with period P, a marker rises every P clocks. After reset the first marker rises on the 3564th rising clock edge, and after a general reset it rises on the Pth edge after the write edge.
- R3: Register port, written on a rising edge when cfg_we is high and read combinationally on cfg_rdata: address 0 is control (bit 0 = automatic mode, bits 2:1 = source select); address 1 is coarse delay (12 bits); address 2 is width (8 bits); address 3 is period (12 bits); address 4 reads the marker count; address 5 bit 0 reads the loss flag, and writing 1 to it clears the flag; writing 1 to bit 0 at address 7 issues the general reset.
- R4: In automatic mode with delay 0, a rising edge of the selected input that is first sampled at clock edge k makes orbit_out rise after edge k+1 and restarts the period from that point.
- R5: A delay of d postpones that rise by exactly d clocks. A new input edge that arrives while a delay is pending restarts the delay and cancels the pending marker.
- R6: Inputs that are not selected, and all inputs while in manual mode, have no effect on the output.
- R7: The output stays high for W clocks. A width of 0 acts as 1, a width of P or more is clamped to P-1, and a period below 2 acts as 2.
- R8: The marker count increments by one for every generated marker.
- R9: In automatic mode, if no selected edge arrives for P+MARGIN clocks, orbit_lost rises and stays high while the output keeps free-running at period P. The flag is cleared only by a clear write or by a general reset.
- R10: A general reset clears the count, the loss flag, the pending delay and the pulse generator, and keeps all configuration registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| orbit_in | input | N_SRC | Candidate turn markers, synchronous to clk |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| orbit_out | output | 1 | Regenerated turn marker |
| orbit_lost | output | 1 | Sticky flag: selected source missing |

## Verification
The bench builds the block with its default parameters: four sources, a 24-bit count and a margin of 8. The untouched default period of 3564 is measured exactly once, straight after reset. Every later scenario reprograms the period to between 1 and 200 clocks. At those lengths the width clamp, the period floor, delay restart, loss detection and free-running after loss all fall within a few dozen cycles, so each can be checked at its exact edge.

// File: rtl/orbit_marker_gen.sv
`timescale 1ns/1ps
module orbit_marker_gen #(
  parameter int N_SRC      = 4,
  parameter int DLY_W      = 12,
  parameter int WID_W      = 8,
  parameter int PER_W      = 12,
  parameter int CNT_W      = 24,
  parameter int MARGIN     = 8,
  parameter int DEF_PERIOD = 3564
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] orbit_in,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [15:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             orbit_out,
  output logic             orbit_lost
);
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int WD_W  = $clog2((1 << PER_W) + MARGIN + 1);

  logic             auto_q;
  logic [SEL_W-1:0] sel_q;
  logic [DLY_W-1:0] dly_q;
  logic [WID_W-1:0] wid_q;
  logic [PER_W-1:0] per_q;

  logic             s1, s2, edge_det;
  logic [DLY_W-1:0] dly_cnt;
  logic [PER_W-1:0] phase;
  logic             started;
  logic [CNT_W-1:0] count;
  logic [WD_W-1:0]  wd;

  logic [PER_W-1:0] per_eff, wid_one, wid_eff;
  logic [WD_W-1:0]  wd_limit;
  logic             greset, lclr, wrap, dly_fire, fire;
  logic             unused_wbits;

  assign unused_wbits = ^cfg_wdata;

  assign greset = cfg_we && cfg_addr == 3'd7 && cfg_wdata[0];
  assign lclr   = cfg_we && cfg_addr == 3'd5 && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
      sel_q  <= '0;
      dly_q  <= '0;
      wid_q  <= WID_W'(1);
      per_q  <= PER_W'(DEF_PERIOD);
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: begin
          auto_q <= cfg_wdata[0];
          sel_q  <= cfg_wdata[SEL_W:1];
        end
        3'd1: dly_q <= cfg_wdata[DLY_W-1:0];
        3'd2: wid_q <= cfg_wdata[WID_W-1:0];
        3'd3: per_q <= cfg_wdata[PER_W-1:0];
        default: ;
      endcase
    end
  end

  assign per_eff  = (per_q < PER_W'(2)) ? PER_W'(2) : per_q;
  assign wid_one  = (wid_q == '0) ? PER_W'(1) : PER_W'(wid_q);
  assign wid_eff  = (wid_one >= per_eff) ? per_eff - PER_W'(1) : wid_one;
  assign wd_limit = WD_W'(per_eff) + WD_W'(MARGIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= orbit_in[sel_q];
      s2 <= s1;
    end
  end

  assign edge_det = auto_q && s1 && !s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dly_cnt <= '0;
    else if (greset)           dly_cnt <= '0;
    else if (edge_det)         dly_cnt <= dly_q;
    else if (dly_cnt != '0)    dly_cnt <= dly_cnt - DLY_W'(1);
  end

  assign dly_fire = auto_q && ((edge_det && dly_q == '0) ||
                               (!edge_det && dly_cnt == DLY_W'(1)));
  assign wrap     = phase >= per_eff - PER_W'(1);
  assign fire     = !greset && (wrap || dly_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      started <= 1'b0;
      count   <= '0;
    end else if (greset) begin
      phase   <= '0;
      started <= 1'b0;
      count   <= '0;
    end else if (fire) begin
      phase   <= '0;
      started <= 1'b1;
      count   <= count + CNT_W'(1);
    end else begin
      phase   <= phase + PER_W'(1);
    end
  end

  assign orbit_out = started && (phase < wid_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          wd <= '0;
    else if (greset || !auto_q || edge_det) wd <= '0;
    else if (wd < wd_limit)              wd <= wd + WD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          orbit_lost <= 1'b0;
    else if (greset || lclr)             orbit_lost <= 1'b0;
    else if (auto_q && wd >= wd_limit)   orbit_lost <= 1'b1;
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      3'd0: begin
        cfg_rdata[0]       = auto_q;
        cfg_rdata[SEL_W:1] = sel_q;
      end
      3'd1: cfg_rdata[DLY_W-1:0] = dly_q;
      3'd2: cfg_rdata[WID_W-1:0] = wid_q;
      3'd3: cfg_rdata[PER_W-1:0] = per_q;
      3'd4: cfg_rdata[CNT_W-1:0] = count;
      3'd5: cfg_rdata[0]         = orbit_lost;
      default: ;
    endcase
  end

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> count == CNT_W'($past(count) + CNT_W'(1)));

  // R9
  loss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    orbit_lost && !greset && !lclr |=> orbit_lost);

  // R5
  dly_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_cnt > DLY_W'(1)) && !edge_det && !greset |=> dly_cnt == $past(dly_cnt) - DLY_W'(1));

  // R7
  rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(orbit_out) |-> phase == '0);

  // R10
  greset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    greset |=> count == '0 && !orbit_out && !orbit_lost && dly_cnt == '0);

  // R2
  fire_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> phase == '0 && started);
endmodule

// File: tb/orbit_marker_gen_test.sv
`timescale 1ns/1ps
module orbit_marker_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        orbit_out, orbit_lost;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  orbit_marker_gen uut (
    .clk(clk), .rst_n(rst_n), .orbit_in(src), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .orbit_out(orbit_out), .orbit_lost(orbit_lost)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    cfg_addr = a;
    #1;
    v = cfg_rdata;
  endtask

  task automatic wait_rise(input int max, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!orbit_out && n < max);
  endtask

  task automatic high_len(output int n);
    n = 1;
    forever begin
      tick();
      if (orbit_out) n++;
      else break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    int n, h;
    chk("R1 out", orbit_out, 0);
    chk("R1 lost", orbit_lost, 0);
    rd(3'd4, v); chk("R1 count", v, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd3, v); chk("R1 period", v, 3564);
    wait_rise(4000, n); chk("R2 first default marker", n, 3564);
    high_len(h); chk("R7 default width", h, 1);
    wait_rise(4000, n); chk("R2 default period", n + h, 3564);
  endtask

  task automatic t_manual();
    logic [31:0] v;
    int n, h;
    wr(3'd0, 16'd0); wr(3'd3, 16'd20); wr(3'd2, 16'd3); wr(3'd7, 16'd1);
    wait_rise(100, n); chk("R2 after general reset", n, 20);
    high_len(h); chk("R7 width 3", h, 3);
    wait_rise(100, n); chk("R2 period 20", n + h, 20);
    rd(3'd4, v); chk("R8 count two", v, 2);
  endtask

  task automatic t_ignore_manual();
    int first = 0;
    wr(3'd3, 16'd40); wr(3'd2, 16'd1); wr(3'd7, 16'd1);
    for (int i = 1; i <= 45; i++) begin
      if (i == 5) src = 4'b0001;
      if (i == 8) src = 4'b0000;
      tick();
      if (orbit_out && first == 0) first = i;
    end
    chk("R6 manual ignores input", first, 40);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    int n, h, first;
    wr(3'd3, 16'd200); wr(3'd2, 16'd2); wr(3'd1, 16'd0); wr(3'd0, 16'd3); wr(3'd7, 16'd1);
    rd(3'd0, v); chk("R3 ctrl readback", v, 3);
    src = 4'b0010;
    wait_rise(50, n); chk("R4 zero delay lock", n, 2);
    high_len(h); chk("R7 width 2 auto", h, 2);
    src = 4'b0000;
    rd(3'd4, v); chk("R8 count after lock", v, 1);
    wr(3'd1, 16'd5); wr(3'd7, 16'd1);
    src = 4'b0010;
    wait_rise(50, n); chk("R5 delay 5", n, 7);
    src = 4'b0000;
    wr(3'd1, 16'd10); wr(3'd7, 16'd1);
    first = 0;
    for (int i = 1; i <= 25; i++) begin
      if (i == 1) src = 4'b0010;
      if (i == 2) src = 4'b0000;
      if (i == 6) src = 4'b0010;
      if (i == 7) src = 4'b0000;
      tick();
      if (orbit_out && first == 0) first = i;
    end
    chk("R5 delay restart", first, 17);
    wr(3'd1, 16'd0); wr(3'd7, 16'd1);
    first = 0;
    for (int i = 1; i <= 30; i++) begin
      if (i == 3) src = 4'b1101;
      if (i == 6) src = 4'b0000;
      tick();
      if (orbit_out && first == 0) first = i;
    end
    chk("R6 unselected inputs ignored", first, 0);
  endtask

  task automatic t_width();
    int n, h;
    wr(3'd0, 16'd0); wr(3'd3, 16'd10); wr(3'd2, 16'd255); wr(3'd7, 16'd1);
    wait_rise(50, n); chk("R7 clamp period 10", n, 10);
    high_len(h); chk("R7 width clamped to 9", h, 9);
    wr(3'd2, 16'd0);
    wait_rise(50, n);
    high_len(h); chk("R7 width 0 acts as 1", h, 1);
    wr(3'd3, 16'd1); wr(3'd2, 16'd5);
    wait_rise(50, n);
    high_len(h); chk("R7 width under period floor", h, 1);
    wait_rise(50, n); chk("R7 period floor 2", n + h, 2);
  endtask

  task automatic t_counter();
    logic [31:0] v;
    wr(3'd3, 16'd5); wr(3'd2, 16'd1); wr(3'd7, 16'd1);
    repeat (35) tick();
    rd(3'd4, v); chk("R8 seven markers", v, 7);
  endtask

  task automatic t_loss();
    logic [31:0] v;
    int n;
    int rises = 0;
    int second = 0;
    wr(3'd3, 16'd30); wr(3'd2, 16'd1); wr(3'd1, 16'd0); wr(3'd0, 16'd1); wr(3'd7, 16'd1);
    for (int i = 1; i <= 42; i++) begin
      if (i == 1) src = 4'b0001;
      if (i == 3) src = 4'b0000;
      tick();
      if (orbit_out) begin
        rises++;
        if (rises == 2) second = i;
      end
      if (i == 39) chk("R9 not yet lost", orbit_lost, 0);
      if (i == 42) chk("R9 lost raised", orbit_lost, 1);
    end
    chk("R9 free-run after edge", second, 32);
    wait_rise(100, n); chk("R9 free-run after loss", n, 20);
    repeat (50) tick();
    rd(3'd5, v); chk("R9 sticky", v, 1);
    wr(3'd5, 16'd1);
    chk("R9 clear write", orbit_lost, 0);
    tick();
    chk("R9 re-raised while missing", orbit_lost, 1);
  endtask

  task automatic t_greset();
    logic [31:0] v;
    wr(3'd7, 16'd1);
    chk("R10 lost cleared", orbit_lost, 0);
    chk("R10 out low", orbit_out, 0);
    rd(3'd4, v); chk("R10 count cleared", v, 0);
    rd(3'd3, v); chk("R10 period kept", v, 30);
    rd(3'd0, v); chk("R10 ctrl kept", v, 1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_manual();
    t_ignore_manual();
    t_auto();
    t_width();
    t_counter();
    t_loss();
    t_greset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule